// File: doc/BRIEF.md
# Watermark-Driven Pause Frame Requester

This block sits beside a full-duplex Ethernet MAC transmitter. It watches the fill levels of four priority receive queues and asks the MAC to send pause control frames when an enabled queue becomes congested. Each queue has its own flow-control enable. All queues share one high watermark. The request carries a 16-bit pause time value. While congestion lasts, the request is repeated at one of three fixed intervals. These intervals are counted on a time-base tick input.

A manual mode sits beside the automatic one. In manual mode, watermark crossings only set sticky per-queue interrupt flags. A pause goes out only when software pulses a one-shot command input. The block issues a single-cycle request strobe and a pending flag. The pending flag holds until the MAC acknowledges. Triggers that arrive while a request is pending are merged into it. When the link runs half duplex, no request is ever made.

Top module: `pfc_pause_requester`

## Requirements
- R1: After reset, `pause_req`, `pause_pending`, `pause_quanta` and `irq_flags` are all zero.
- R2: In automatic mode (`auto_mode`=1) and full duplex, the request fires on the clock edge where the block first sees a level strictly above `high_wm`. The condition is that `pause_req` was low and queue i has `q_enable[i]`=1, with queue i's level in `q_level[i*LVL_W +: LVL_W]`. `pause_req` is then high for exactly one cycle. A level equal to the watermark does not count as congestion.
- R3: `pause_quanta` takes the value of `pause_time` on the edge that raises `pause_req`. It holds that value while the request is pending.
- R4: A queue whose enable bit is 0 never causes a pause request. Setting its enable bit while its level is above the watermark counts as the start of congestion.
- R5: While congestion lasts in automatic mode, a new trigger is raised every N ticks after the previous one. The interval is chosen by `period_sel`: 00 gives 16.4 us, 01 gives 164 us, 10 gives 1.64 ms, and 11 behaves as 00. N is that time divided by `TICK_NS`, so with the default of 100 ns N is 164, 1640 and 16400. Only cycles with `tick`=1 count.
- R6: Once every enabled queue is at or below the watermark, no further request is raised.
- R7: `pause_pending` rises together with `pause_req` and stays high until a cycle with `mac_ack`=1. A trigger that arrives while the request is pending causes no new strobe.
- R8: With `auto_mode`=0, crossings raise no request. A one-cycle `manual_cmd` in full duplex raises `pause_req` on the next edge, provided no request is pending.
- R9: `irq_flags[i]` is set on the edge after queue i's level goes from at or below the watermark to above it. This happens whatever the enable bit or mode. The flag stays set until a cycle with `irq_clr[i]`=1, and a new crossing in that same cycle wins over the clear.
- R10: While `full_duplex`=0, no pause request is made, whether from a crossing or from `manual_cmd`. A return to full duplex while a queue is still congested counts as the start of congestion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | Link runs full duplex |
| auto_mode | input | 1 | 1 = automatic pausing, 0 = manual |
| q_enable | input | NUM_Q | Per-queue flow-control enable |
| high_wm | input | LVL_W | Shared high watermark |
| q_level | input | NUM_Q*LVL_W | Fill levels, queue i at bits i*LVL_W upward |
| pause_time | input | 16 | Pause time value for new requests |
| period_sel | input | 2 | Retransmit interval select |
| manual_cmd | input | 1 | One-shot manual pause command |
| tick | input | 1 | Time-base tick, one every TICK_NS |
| irq_clr | input | NUM_Q | Write-one-to-clear for interrupt flags |
| mac_ack | input | 1 | MAC accepted the pending request |
| pause_req | output | 1 | Single-cycle request strobe |
| pause_pending | output | 1 | Request awaiting acknowledge |
| pause_quanta | output | 16 | Pause time carried by the request |
| irq_flags | output | NUM_Q | Sticky watermark-crossing flags |

## Verification
Some rules are checked by the assertions on every cycle. Half duplex and manual mode without a command never strobe. A pending, unacknowledged request blocks new strobes and keeps its pause value steady. Flags stay set until cleared. A new rise in automatic mode strobes at once. Other behaviour shows only in the bench's scenarios. This covers the exact spacing of repeats for each interval code, the silence after the queues drain, and the strict-greater-than comparison at the watermark. It also covers the effect of enabling a queue that is already full, and the set-over-clear rule for the interrupt flags.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  // Retransmit interval in nanoseconds for each select code; 11 reuses 00.
  function automatic int unsigned retx_ns(input logic [1:0] sel);
    case (sel)
      2'b01:   retx_ns = 164000;
      2'b10:   retx_ns = 1640000;
      default: retx_ns = 16400;
    endcase
  endfunction

  function automatic int unsigned retx_ticks(input logic [1:0] sel, input int unsigned tick_ns);
    retx_ticks = retx_ns(sel) / tick_ns;
  endfunction

  function automatic int unsigned retx_cnt_bits(input int unsigned tick_ns);
    retx_cnt_bits = $clog2(retx_ns(2'b10) / tick_ns + 1);
  endfunction

  // Congestion test: strictly above the mark.
  function automatic logic above_mark(input logic [31:0] lvl, input logic [31:0] mark);
    above_mark = (lvl > mark);
  endfunction

endpackage

// File: rtl/pfc_level_monitor.sv
module pfc_level_monitor #(
  parameter int NUM_Q = 4,
  parameter int LVL_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_Q*LVL_W-1:0] q_level,
  input  logic [LVL_W-1:0]       high_wm,
  input  logic [NUM_Q-1:0]       q_enable,
  input  logic [NUM_Q-1:0]       irq_clr,
  output logic [NUM_Q-1:0]       over_raw,
  output logic [NUM_Q-1:0]       over_en,
  output logic [NUM_Q-1:0]       irq_flags
);
  import pfc_pkg::*;

  logic [NUM_Q-1:0] over_q;
  logic [NUM_Q-1:0] cross_up;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign over_raw[i] = above_mark(32'(q_level[i*LVL_W +: LVL_W]), 32'(high_wm));
    assign over_en[i]  = over_raw[i] & q_enable[i];
    assign cross_up[i] = over_raw[i] & ~over_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        over_q[i]    <= 1'b0;
        irq_flags[i] <= 1'b0;
      end else begin
        over_q[i]    <= over_raw[i];
        irq_flags[i] <= (irq_flags[i] & ~irq_clr[i]) | cross_up[i];
      end
    end
  end

endmodule

// File: rtl/pfc_retx_timer.sv
module pfc_retx_timer #(
  parameter int TICK_NS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       restart,
  input  logic       tick,
  input  logic [1:0] period_sel,
  output logic       expire
);
  import pfc_pkg::*;

  localparam int CW = retx_cnt_bits(TICK_NS);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          at_end;

  assign limit  = CW'(retx_ticks(period_sel, TICK_NS));
  assign at_end = (cnt == limit - CW'(1));
  assign expire = active & tick & ~restart & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active || restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= at_end ? '0 : cnt + CW'(1);
    end
  end

endmodule

// File: rtl/pfc_req_issue.sv
module pfc_req_issue #(
  parameter int PT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            mac_ack,
  input  logic [PT_W-1:0] pause_time,
  output logic            issue,
  output logic            pause_req,
  output logic            pause_pending,
  output logic [PT_W-1:0] pause_quanta
);

  assign issue = trig & ~pause_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_req     <= 1'b0;
      pause_pending <= 1'b0;
      pause_quanta  <= '0;
    end else begin
      pause_req     <= issue;
      pause_pending <= issue | (pause_pending & ~mac_ack);
      if (issue) pause_quanta <= pause_time;
    end
  end

endmodule

// File: rtl/pfc_pause_requester.sv
module pfc_pause_requester #(
  parameter int NUM_Q   = 4,
  parameter int LVL_W   = 12,
  parameter int TICK_NS = 100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   full_duplex,
  input  logic                   auto_mode,
  input  logic [NUM_Q-1:0]       q_enable,
  input  logic [LVL_W-1:0]       high_wm,
  input  logic [NUM_Q*LVL_W-1:0] q_level,
  input  logic [15:0]            pause_time,
  input  logic [1:0]             period_sel,
  input  logic                   manual_cmd,
  input  logic                   tick,
  input  logic [NUM_Q-1:0]       irq_clr,
  input  logic                   mac_ack,
  output logic                   pause_req,
  output logic                   pause_pending,
  output logic [15:0]            pause_quanta,
  output logic [NUM_Q-1:0]       irq_flags
);

  logic [NUM_Q-1:0] over_raw;
  logic [NUM_Q-1:0] over_en;
  logic             congested;
  logic             cong_q;
  logic             cong_rise;
  logic             retx_expire;
  logic             trig;
  logic             issue;

  pfc_level_monitor #(.NUM_Q(NUM_Q), .LVL_W(LVL_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .q_level(q_level), .high_wm(high_wm),
    .q_enable(q_enable), .irq_clr(irq_clr), .over_raw(over_raw),
    .over_en(over_en), .irq_flags(irq_flags)
  );

  assign congested = full_duplex & (|over_en);
  assign cong_rise = congested & ~cong_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cong_q <= 1'b0;
    else        cong_q <= congested;
  end

  pfc_retx_timer #(.TICK_NS(TICK_NS)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(congested & auto_mode),
    .restart(cong_rise), .tick(tick), .period_sel(period_sel),
    .expire(retx_expire)
  );

  assign trig = full_duplex & (auto_mode ? (cong_rise | retx_expire) : manual_cmd);

  pfc_req_issue #(.PT_W(16)) u_issue (
    .clk(clk), .rst_n(rst_n), .trig(trig), .mac_ack(mac_ack),
    .pause_time(pause_time), .issue(issue), .pause_req(pause_req),
    .pause_pending(pause_pending), .pause_quanta(pause_quanta)
  );

endmodule

// File: rtl/pfc_pause_requester_chk.sv
module pfc_pause_requester_chk #(
  parameter int NUM_Q = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full_duplex,
  input logic             auto_mode,
  input logic             manual_cmd,
  input logic             mac_ack,
  input logic             cong_rise,
  input logic [NUM_Q-1:0] irq_clr,
  input logic             pause_req,
  input logic             pause_pending,
  input logic [15:0]      pause_quanta,
  input logic [NUM_Q-1:0] irq_flags
);

  AST_HALF_DUPLEX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !full_duplex |=> !pause_req); // R10

  AST_MERGE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_pending && !mac_ack) |=> !pause_req); // R7

  AST_STROBE_WITH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> pause_pending); // R7

  AST_QUANTA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_pending && !mac_ack) |=> $stable(pause_quanta)); // R3

  AST_MANUAL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && !manual_cmd) |=> !pause_req); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr))); // R9

  AST_AUTO_RISE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && cong_rise && !pause_pending) |=> pause_req); // R2

endmodule

bind pfc_pause_requester pfc_pause_requester_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .auto_mode(auto_mode),
  .manual_cmd(manual_cmd), .mac_ack(mac_ack), .cong_rise(cong_rise),
  .irq_clr(irq_clr), .pause_req(pause_req), .pause_pending(pause_pending),
  .pause_quanta(pause_quanta), .irq_flags(irq_flags)
);

// File: tb/test_pfc_pause_requester.sv
module test_pfc_pause_requester;

  localparam int NQ = 4;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          full_duplex = 1'b1;
  logic          auto_mode = 1'b1;
  logic [NQ-1:0] q_enable = '0;
  logic [LW-1:0] high_wm = 8'd100;
  logic [NQ*LW-1:0] q_level = '0;
  logic [15:0]   pause_time = 16'h1234;
  logic [1:0]    period_sel = 2'b10;
  logic          manual_cmd = 1'b0;
  logic          tick = 1'b0;
  logic [NQ-1:0] irq_clr = '0;
  logic          mac_ack = 1'b0;
  logic          pause_req;
  logic          pause_pending;
  logic [15:0]   pause_quanta;
  logic [NQ-1:0] irq_flags;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfc_pause_requester #(.NUM_Q(NQ), .LVL_W(LW), .TICK_NS(100)) i_pfc_pause_requester (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .auto_mode(auto_mode),
    .q_enable(q_enable), .high_wm(high_wm), .q_level(q_level),
    .pause_time(pause_time), .period_sel(period_sel), .manual_cmd(manual_cmd),
    .tick(tick), .irq_clr(irq_clr), .mac_ack(mac_ack), .pause_req(pause_req),
    .pause_pending(pause_pending), .pause_quanta(pause_quanta), .irq_flags(irq_flags)
  );

  // Vector: fd au en[4] l0 l1 l2 l3 man ack clr[4] | exp pulse, pending, flags[4]
  localparam int VN = 20;
  localparam logic [49:0] TBL [0:VN-1] = '{
    {1'b1,1'b1,4'b0001,8'd0,  8'd0,  8'd0,  8'd0,  1'b0,1'b0,4'b0000, 1'b0,1'b0,4'b0000}, // R2 idle
    {1'b1,1'b1,4'b0001,8'd100,8'd0,  8'd0,  8'd0,  1'b0,1'b0,4'b0000, 1'b0,1'b0,4'b0000}, // R2 equal mark
    {1'b1,1'b1,4'b0001,8'd101,8'd0,  8'd0,  8'd0,  1'b0,1'b0,4'b0000, 1'b1,1'b1,4'b0001}, // R2 cross
    {1'b1,1'b1,4'b0001,8'd101,8'd0,  8'd0,  8'd0,  1'b0,1'b1,4'b0000, 1'b0,1'b0,4'b0001}, // R7 ack
    {1'b1,1'b1,4'b0001,8'd101,8'd150,8'd0,  8'd0,  1'b0,1'b0,4'b0000, 1'b0,1'b0,4'b0011}, // R4 disabled q1
    {1'b1,1'b1,4'b0001,8'd50, 8'd150,8'd0,  8'd0,  1'b0,1'b0,4'b0001, 1'b0,1'b0,4'b0010}, // R9 clear
    {1'b1,1'b1,4'b0011,8'd50, 8'd150,8'd0,  8'd0,  1'b0,1'b0,4'b0000, 1'b1,1'b1,4'b0010}, // R4 enable full q
    {1'b1,1'b1,4'b0111,8'd50, 8'd150,8'd200,8'd0,  1'b0,1'b0,4'b0000, 1'b0,1'b1,4'b0110}, // R7 pending
    {1'b1,1'b1,4'b0111,8'd0,  8'd0,  8'd0,  8'd0,  1'b0,1'b0,4'b0000, 1'b0,1'b1,4'b0110}, // R6 drained
    {1'b1,1'b1,4'b1111,8'd0,  8'd0,  8'd0,  8'd255,1'b0,1'b0,4'b0000, 1'b0,1'b1,4'b1110}, // R7 merge
    {1'b1,1'b1,4'b1111,8'd0,  8'd0,  8'd0,  8'd255,1'b0,1'b1,4'b0000, 1'b0,1'b0,4'b1110}, // R7 ack
    {1'b1,1'b0,4'b1111,8'd0,  8'd0,  8'd0,  8'd0,  1'b0,1'b0,4'b1111, 1'b0,1'b0,4'b0000}, // R9 clear all
    {1'b1,1'b0,4'b1111,8'd0,  8'd0,  8'd0,  8'd255,1'b0,1'b0,4'b0000, 1'b0,1'b0,4'b1000}, // R8 crossing only
    {1'b1,1'b0,4'b1111,8'd0,  8'd0,  8'd0,  8'd255,1'b1,1'b0,4'b0000, 1'b1,1'b1,4'b1000}, // R8 command
    {1'b1,1'b0,4'b1111,8'd0,  8'd0,  8'd0,  8'd255,1'b0,1'b1,4'b0000, 1'b0,1'b0,4'b1000}, // R7 ack
    {1'b0,1'b1,4'b1111,8'd0,  8'd0,  8'd0,  8'd0,  1'b0,1'b0,4'b0000, 1'b0,1'b0,4'b1000}, // R10 half
    {1'b0,1'b1,4'b1111,8'd0,  8'd0,  8'd0,  8'd255,1'b0,1'b0,4'b0000, 1'b0,1'b0,4'b1000}, // R10 crossing
    {1'b0,1'b1,4'b1111,8'd0,  8'd0,  8'd0,  8'd255,1'b1,1'b0,4'b0000, 1'b0,1'b0,4'b1000}, // R10 command
    {1'b1,1'b1,4'b1111,8'd0,  8'd0,  8'd0,  8'd255,1'b0,1'b0,4'b0000, 1'b1,1'b1,4'b1000}, // R10 back to full
    {1'b1,1'b1,4'b1111,8'd0,  8'd0,  8'd0,  8'd0,  1'b0,1'b1,4'b1000, 1'b0,1'b0,4'b0000}  // R9 R7 tidy
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    full_duplex = 1'b1; auto_mode = 1'b1; q_enable = '0; q_level = '0;
    manual_cmd = 1'b0; tick = 1'b0; irq_clr = '0; mac_ack = 1'b0;
    pause_time = 16'h1234; period_sel = 2'b10;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Interval in ticks, from the 16.4 us / 164 us / 1.64 ms rule at 100 ns per tick.
  function automatic int exp_interval(input logic [1:0] sel);
    if (sel == 2'b01) return 1640;
    if (sel == 2'b10) return 16400;
    return 164;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R1: reset state
    chk({pause_req, pause_pending, pause_quanta, irq_flags} == '0, "R1", "reset outputs",
        32'({pause_req, pause_pending, pause_quanta, irq_flags}), 32'd0);

    // Table walk
    for (int k = 0; k < VN; k++) begin
      logic [49:0] v;
      v = TBL[k];
      @(negedge clk);
      full_duplex = v[49]; auto_mode = v[48]; q_enable = v[47:44];
      q_level = {v[19:12], v[27:20], v[35:28], v[43:36]};
      manual_cmd = v[11]; mac_ack = v[10]; irq_clr = v[9:6];
      step();
      chk({pause_req, pause_pending, irq_flags} == v[5:0], "R2/R4/R6/R7/R8/R9/R10",
          $sformatf("vector %0d", k), 32'({pause_req, pause_pending, irq_flags}), 32'(v[5:0]));
    end
    @(negedge clk);
    manual_cmd = 1'b0; mac_ack = 1'b0; irq_clr = '0;

    // R5 R6: retransmit spacing for each select code
    for (int s = 0; s < 4; s++) begin
      int first_at;
      int second_at;
      int lim;
      first_at = -1; second_at = -1;
      lim = exp_interval(2'(s));
      do_reset();
      @(negedge clk);
      period_sel = 2'(s); q_enable = 4'b0001; mac_ack = 1'b1; tick = 1'b1;
      q_level[LW-1:0] = 8'd200;
      for (int c = 0; c < lim + 50 && second_at < 0; c++) begin
        step();
        if (pause_req) begin
          if (first_at < 0) first_at = c;
          else second_at = c;
        end
      end
      chk(first_at == 0, "R5", $sformatf("first strobe sel %0d", s), 32'(first_at), 32'd0);
      chk(second_at - first_at == lim, "R5", $sformatf("interval sel %0d", s),
          32'(second_at - first_at), 32'(lim));
      if (s == 0) begin
        int extra;
        extra = 0;
        @(negedge clk);
        q_level[LW-1:0] = 8'd100;
        for (int c = 0; c < lim * 2 + 20; c++) begin
          step();
          if (pause_req) extra++;
        end
        chk(extra == 0, "R6", "no repeat after drain", 32'(extra), 32'd0);
      end
    end

    // R3: quanta captured at issue and held while pending
    do_reset();
    @(negedge clk);
    q_enable = 4'b0001; q_level[LW-1:0] = 8'd150;
    step();
    chk(pause_req && pause_quanta == 16'h1234, "R3", "quanta at issue",
        32'(pause_quanta), 32'h1234);
    @(negedge clk);
    pause_time = 16'hABCD; q_level[LW-1:0] = 8'd0;
    repeat (3) step();
    chk(pause_quanta == 16'h1234, "R3", "quanta held while pending",
        32'(pause_quanta), 32'h1234);
    @(negedge clk);
    mac_ack = 1'b1;
    step();
    @(negedge clk);
    mac_ack = 1'b0; q_level[LW-1:0] = 8'd150;
    step();
    chk(pause_req && pause_quanta == 16'hABCD, "R3", "new quanta on next issue",
        32'(pause_quanta), 32'hABCD);

    // R9: a new crossing wins over a clear in the same cycle
    do_reset();
    @(negedge clk);
    q_level[LW-1:0] = 8'd101;
    step();
    @(negedge clk);
    q_level[LW-1:0] = 8'd20;
    step();
    @(negedge clk);
    q_level[LW-1:0] = 8'd101; irq_clr = 4'b0001;
    step();
    chk(irq_flags[0] == 1'b1, "R9", "set wins over clear", 32'(irq_flags), 32'd1);
    chk(pause_req == 1'b0, "R4", "disabled queue no strobe", 32'(pause_req), 32'd0);
    @(negedge clk);
    irq_clr = 4'b0000;

    // R1: reset mid-run clears state
    @(negedge clk);
    q_enable = 4'b0001; q_level[LW-1:0] = 8'd20;
    step();
    @(negedge clk);
    q_level[LW-1:0] = 8'd180;
    step();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({pause_req, pause_pending, pause_quanta, irq_flags} == '0, "R1", "reset mid-run",
        32'({pause_req, pause_pending, pause_quanta, irq_flags}), 32'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule